// File: doc/BRIEF.md
# Edge-Counting Pulse Accumulator with Overflow Flag

This block counts active edges on a single external input. The input is synchronized into the clock domain, and a control bit picks whether a rising or a falling transition counts. The count register works either as a full 16-bit counter or as a narrow 8-bit counter. In narrow mode an optional max-hold setting stops the count at its top value instead of letting it wrap.

Any overflow event sets a sticky overflow flag. An overflow event is a wrap of the active counter width, or an active edge that arrives while a held narrow count is already at its top. Software reads and clears the flag over a small synchronous register bus. Normally, writing a one to the flag bit clears it. When fast-clear mode is selected, that write has no effect, and any bus access to the count register clears the flag instead. A single interrupt request output follows the flag, gated by an enable bit.

Register map (`bus_addr_i`):
- Address 0 is the control register. Its fields are: bit 0 count enable, bit 1 falling-edge select, bit 2 narrow (8-bit) mode, bit 3 max-hold, bit 4 fast-clear mode, bit 5 interrupt enable.
- Address 1 is the count register.
- Address 2 is the flag register. The overflow flag sits at bit 1.

Reads return the addressed register combinationally on `bus_rdata_o`. A write or read strobe takes effect at the clock edge during which `bus_sel_i` is high.

Top module: `pulse_acc_top`

## Requirements
- R1: After reset the control register, the count register, the flag register and `irq_o` are all zero.
- R2: With control bit 1 at 0, only rising transitions of `pin_i` are counted. With control bit 1 at 1, only falling transitions are counted. Each counted edge adds one to the count, at most three clock edges after the pin changes.
- R3: In 16-bit mode (control bit 2 at 0), an active edge at count 0xFFFF wraps the count to 0x0000 and sets the overflow flag.
- R4: In narrow mode (control bit 2 at 1) without max-hold, an active edge at count 0x00FF wraps the count to 0x0000 and sets the flag. In narrow mode the upper byte of the count always reads as zero.
- R5: In narrow mode with max-hold (control bit 3 at 1), the count stops at 0x00FF. A further active edge leaves it at 0x00FF and sets the flag.
- R6: With fast-clear off, writing the flag register with bit 1 set clears the flag. A write with bit 1 at 0 leaves the flag unchanged, whatever the other bits hold.
- R7: With fast-clear on (control bit 4 at 1), writing one to flag bit 1 does not clear the flag. Any bus read or write of the count register clears it.
- R8: With control bit 0 at 0, edges on `pin_i` are ignored and the count holds its value.
- R9: When an overflow event and a flag clear happen in the same clock cycle, the flag ends up set.
- R10: `irq_o` is high exactly when the overflow flag is set and control bit 5 is 1.
- R11: The flag register reads bit 1 as the flag and every other bit as zero.
- R12: A bus write to the count register loads the count. In narrow mode only the low byte is loaded and the upper byte becomes zero. A counting edge in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Asynchronous pulse input being counted |
| bus_sel_i | input | 1 | Register bus select |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe (used for fast-clear on count reads) |
| bus_addr_i | input | 2 | Register address: 0 control, 1 count, 2 flag |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data of the addressed register |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The counter is driven with trains of full pulses under each edge polarity. One pulse adds exactly one in either polarity, and a half pulse shows which transition was taken. Counts preloaded just below the 16-bit and 8-bit tops separate a true wrap from a held maximum and show that the flag rises only on the wrapping edge. Clear attempts are issued in both clear modes, including a write with every bit except bit 1 set. A clear strobe is placed in exactly the cycle an overflowing edge is registered, which shows that setting wins over clearing.

// File: rtl/pa_pkg.sv
package pa_pkg;

    typedef struct packed {
        logic irq_en;
        logic fast_clr;
        logic max_hold;
        logic narrow;
        logic fall_edge;
        logic enable;
    } pa_ctrl_t;

    localparam int CTRL_BITS = $bits(pa_ctrl_t);

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CNT  = 2'd1;
    localparam logic [1:0] ADDR_FLAG = 2'd2;

    localparam int FLAG_BIT = 1;

endpackage

// File: rtl/pa_edge_sync.sv
module pa_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic fall_sel_i,
    output logic edge_o
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } es_state_t;

    es_state_t st_d, st_q;
    logic      settled;

    generate
        if (STAGES == 1) begin : g_one
            always_comb st_d.sync = pin_i;
        end else begin : g_chain
            always_comb st_d.sync = {st_q.sync[STAGES-2:0], pin_i};
        end
    endgenerate

    always_comb begin
        settled   = st_q.sync[STAGES-1];
        st_d.prev = settled;
        edge_o    = fall_sel_i ? (st_q.prev & ~settled) : (~st_q.prev & settled);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pa_counter.sv
module pa_counter #(
    parameter int CNT_W    = 16,
    parameter int NARROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             narrow_i,
    input  logic             max_hold_i,
    input  logic             edge_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);
    localparam int PAD_W = CNT_W - NARROW_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t            st_d, st_q;
    logic [NARROW_W-1:0]   low_q;
    logic [NARROW_W-1:0]   low_inc;

    always_comb begin
        st_d    = st_q;
        ovf_o   = 1'b0;
        low_q   = st_q.cnt[NARROW_W-1:0];
        low_inc = low_q + 1'b1;
        if (load_i) begin
            st_d.cnt = narrow_i ? {{PAD_W{1'b0}}, load_val_i[NARROW_W-1:0]} : load_val_i;
        end else if (enable_i && edge_i) begin
            if (narrow_i) begin
                if (&low_q) begin
                    ovf_o    = 1'b1;
                    st_d.cnt = max_hold_i ? {{PAD_W{1'b0}}, low_q} : '0;
                end else begin
                    st_d.cnt = {{PAD_W{1'b0}}, low_inc};
                end
            end else begin
                ovf_o    = &st_q.cnt;
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/pa_flag.sv
module pa_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic fast_mode_i,
    input  logic w1c_i,
    input  logic cnt_access_i,
    output logic flag_o
);
    typedef struct packed {
        logic flag;
    } flag_state_t;

    flag_state_t st_d, st_q;
    logic        clear;

    always_comb begin
        clear = fast_mode_i ? cnt_access_i : w1c_i;
        st_d  = st_q;
        if (set_i)      st_d.flag = 1'b1;
        else if (clear) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/pulse_acc_top.sv
module pulse_acc_top #(
    parameter int DATA_W      = 16,
    parameter int NARROW_W    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [1:0]        bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);
    import pa_pkg::*;

    localparam int PAD_W = DATA_W - NARROW_W;

    typedef struct packed {
        pa_ctrl_t ctrl;
    } top_state_t;

    top_state_t        st_d, st_q;
    pa_ctrl_t          ctrl_q;
    logic              edge_w;
    logic              load_w;
    logic              w1c_w;
    logic              cnt_acc_w;
    logic              ovf_w;
    logic              flag_w;
    logic [DATA_W-1:0] cnt_w;

    assign ctrl_q = st_q.ctrl;

    always_comb begin
        st_d = st_q;
        if (bus_sel_i && bus_wr_i && bus_addr_i == ADDR_CTRL)
            st_d.ctrl = pa_ctrl_t'(bus_wdata_i[CTRL_BITS-1:0]);
        load_w    = bus_sel_i && bus_wr_i && bus_addr_i == ADDR_CNT;
        cnt_acc_w = bus_sel_i && (bus_wr_i || bus_rd_i) && bus_addr_i == ADDR_CNT;
        w1c_w     = bus_sel_i && bus_wr_i && bus_addr_i == ADDR_FLAG && bus_wdata_i[FLAG_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    pa_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (pin_i),
        .fall_sel_i (ctrl_q.fall_edge),
        .edge_o     (edge_w)
    );

    pa_counter #(.CNT_W(DATA_W), .NARROW_W(NARROW_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (ctrl_q.enable),
        .narrow_i   (ctrl_q.narrow),
        .max_hold_i (ctrl_q.max_hold),
        .edge_i     (edge_w),
        .load_i     (load_w),
        .load_val_i (bus_wdata_i),
        .cnt_o      (cnt_w),
        .ovf_o      (ovf_w)
    );

    pa_flag u_flag (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_i        (ovf_w),
        .fast_mode_i  (ctrl_q.fast_clr),
        .w1c_i        (w1c_w),
        .cnt_access_i (cnt_acc_w),
        .flag_o       (flag_w)
    );

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            ADDR_CTRL: bus_rdata_o[CTRL_BITS-1:0] = ctrl_q;
            ADDR_CNT:  bus_rdata_o = ctrl_q.narrow ? {{PAD_W{1'b0}}, cnt_w[NARROW_W-1:0]} : cnt_w;
            ADDR_FLAG: bus_rdata_o[FLAG_BIT] = flag_w;
            default:   bus_rdata_o = '0;
        endcase
    end

    assign irq_o = flag_w & ctrl_q.irq_en;
endmodule

// File: rtl/pa_checker.sv
module pa_checker #(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              narrow,
    input logic              max_hold,
    input logic              fast,
    input logic              edge_pulse,
    input logic              load,
    input logic [DATA_W-1:0] cnt,
    input logic              flag,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata
);
    logic step;
    logic flag_w1;
    assign step    = en && edge_pulse && !load;
    assign flag_w1 = bus_sel && bus_wr && bus_addr == 2'd2 && bus_wdata[1];

    p_hold_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load) |=> $stable(cnt));

    p_wrap_wide_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !narrow && cnt == '1) |=> (cnt == '0 && flag));

    p_wrap_narrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && narrow && !max_hold && &cnt[NARROW_W-1:0]) |=> (cnt[NARROW_W-1:0] == '0 && flag));

    p_max_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && narrow && max_hold && &cnt[NARROW_W-1:0]) |=> (&cnt[NARROW_W-1:0] && flag));

    p_fast_no_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fast && flag && flag_w1 && !(bus_addr == 2'd1)) |=> flag);

    p_rise_from_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(en && edge_pulse));

    always @(posedge clk) begin
        if (rst_n && bus_addr == 2'd2) begin
            p_flag_bits_r11: assert ((bus_rdata & ~(DATA_W'(1) << 1)) == '0);
        end
    end
endmodule

bind pulse_acc_top pa_checker #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (ctrl_q.enable),
    .narrow     (ctrl_q.narrow),
    .max_hold   (ctrl_q.max_hold),
    .fast       (ctrl_q.fast_clr),
    .edge_pulse (edge_w),
    .load       (load_w),
    .cnt        (cnt_w),
    .flag       (flag_w),
    .bus_sel    (bus_sel_i),
    .bus_wr     (bus_wr_i),
    .bus_addr   (bus_addr_i),
    .bus_wdata  (bus_wdata_i),
    .bus_rdata  (bus_rdata_o)
);

// File: tb/tb_pulse_acc_top.sv
module tb_pulse_acc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_i = 1'b0;
    logic        bus_sel_i = 1'b0;
    logic        bus_wr_i = 1'b0;
    logic        bus_rd_i = 1'b0;
    logic [1:0]  bus_addr_i = 2'd0;
    logic [15:0] bus_wdata_i = 16'd0;
    logic [15:0] bus_rdata_o;
    logic        irq_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    pulse_acc_top dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
        .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i),
        .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
    );

    localparam logic [1:0] A_CTRL = 2'd0, A_CNT = 2'd1, A_FLAG = 2'd2;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel_i = 1; bus_wr_i = 1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_sel_i = 0; bus_wr_i = 0; bus_wdata_i = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel_i = 1; bus_rd_i = 1; bus_addr_i = a;
        #1 d = bus_rdata_o;
        @(negedge clk);
        bus_sel_i = 0; bus_rd_i = 0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) pin_i = ~pin_i;
            repeat (3) @(negedge clk);
            pin_i = ~pin_i;
            repeat (3) @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(A_CTRL, v); chk("R1 ctrl", v, 16'h0);
        rd(A_CNT, v);  chk("R1 count", v, 16'h0);
        rd(A_FLAG, v); chk("R1 flag", v, 16'h0);
        chk("R1 irq", {15'd0, irq_o}, 16'h0);
    endtask

    task automatic t_edges();
        logic [15:0] v;
        wr(A_CTRL, 16'h0001);
        pulses(5);
        rd(A_CNT, v); chk("R2 rising count", v, 16'd5);
        wr(A_CNT, 16'h0000);
        wr(A_CTRL, 16'h0003);
        @(negedge clk) pin_i = 1;
        repeat (5) @(negedge clk);
        rd(A_CNT, v); chk("R2 rise ignored in falling mode", v, 16'd0);
        @(negedge clk) pin_i = 0;
        repeat (5) @(negedge clk);
        rd(A_CNT, v); chk("R2 falling counted", v, 16'd1);
    endtask

    task automatic t_disabled();
        logic [15:0] v;
        wr(A_CTRL, 16'h0000);
        wr(A_CNT, 16'h0010);
        rd(A_CNT, v); chk("R12 load", v, 16'h0010);
        pulses(3);
        rd(A_CNT, v); chk("R8 hold while disabled", v, 16'h0010);
    endtask

    task automatic t_wide_wrap();
        logic [15:0] v;
        wr(A_CTRL, 16'h0001);
        wr(A_CNT, 16'hFFFE);
        pulses(1);
        rd(A_FLAG, v); chk("R3 no flag before wrap", v, 16'h0);
        rd(A_CNT, v);  chk("R3 at top", v, 16'hFFFF);
        pulses(1);
        rd(A_CNT, v);  chk("R3 wrapped", v, 16'h0000);
        rd(A_FLAG, v); chk("R3 R11 flag set", v, 16'h0002);
        wr(A_FLAG, 16'hFFFD);
        rd(A_FLAG, v); chk("R6 zero write keeps flag", v, 16'h0002);
        wr(A_FLAG, 16'h0002);
        rd(A_FLAG, v); chk("R6 one write clears", v, 16'h0000);
    endtask

    task automatic t_irq();
        logic [15:0] v;
        wr(A_CTRL, 16'h0021);
        chk("R10 irq low, flag clear", {15'd0, irq_o}, 16'h0);
        wr(A_CNT, 16'hFFFF);
        pulses(1);
        chk("R10 irq high", {15'd0, irq_o}, 16'h1);
        wr(A_CTRL, 16'h0001);
        chk("R10 irq masked", {15'd0, irq_o}, 16'h0);
        rd(A_FLAG, v); chk("R10 flag kept", v, 16'h0002);
        wr(A_FLAG, 16'h0002);
    endtask

    task automatic t_narrow();
        logic [15:0] v;
        wr(A_CTRL, 16'h0005);
        wr(A_CNT, 16'h12FE);
        rd(A_CNT, v);  chk("R12 narrow load", v, 16'h00FE);
        pulses(1);
        rd(A_CNT, v);  chk("R4 at top", v, 16'h00FF);
        rd(A_FLAG, v); chk("R4 no flag yet", v, 16'h0);
        pulses(1);
        rd(A_CNT, v);  chk("R4 wrapped", v, 16'h0000);
        rd(A_FLAG, v); chk("R4 flag set", v, 16'h0002);
        wr(A_FLAG, 16'h0002);
        wr(A_CTRL, 16'h000D);
        wr(A_CNT, 16'h00FE);
        pulses(1);
        rd(A_CNT, v);  chk("R5 reached top", v, 16'h00FF);
        rd(A_FLAG, v); chk("R5 no flag at top", v, 16'h0);
        pulses(2);
        rd(A_CNT, v);  chk("R5 held", v, 16'h00FF);
        rd(A_FLAG, v); chk("R5 flag on held edge", v, 16'h0002);
        wr(A_FLAG, 16'h0002);
    endtask

    task automatic t_fast();
        logic [15:0] v;
        wr(A_CTRL, 16'h0011);
        wr(A_CNT, 16'hFFFF);
        pulses(1);
        wr(A_FLAG, 16'h0002);
        rd(A_FLAG, v); chk("R7 one write ignored", v, 16'h0002);
        rd(A_CNT, v);
        rd(A_FLAG, v); chk("R7 count read clears", v, 16'h0000);
        wr(A_CNT, 16'hFFFF);
        pulses(1);
        rd(A_FLAG, v); chk("R7 set again", v, 16'h0002);
        wr(A_CNT, 16'h0005);
        rd(A_FLAG, v); chk("R7 count write clears", v, 16'h0000);
    endtask

    task automatic t_set_wins();
        logic [15:0] v;
        wr(A_CTRL, 16'h0001);
        wr(A_CNT, 16'hFFFF);
        @(negedge clk) pin_i = 1;
        @(negedge clk);
        @(negedge clk);
        bus_sel_i = 1; bus_wr_i = 1; bus_addr_i = A_FLAG; bus_wdata_i = 16'h0002;
        @(negedge clk);
        bus_sel_i = 0; bus_wr_i = 0; bus_wdata_i = 0;
        pin_i = 0;
        repeat (5) @(negedge clk);
        rd(A_FLAG, v); chk("R9 set beats clear", v, 16'h0002);
        rd(A_CNT, v);  chk("R9 count wrapped", v, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        t_reset();
        t_edges();
        t_disabled();
        t_wide_wrap();
        t_irq();
        t_narrow();
        t_fast();
        t_set_wins();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule